// File: doc/BRIEF.md
# Fetch Next-Address Predictor

This block chooses the address a pipelined fetch stage should use next. Each cycle the fetch stage presents the address it is fetching. One cycle later the block reports three things about that fetch: whether the word is a known branch, whether its direction is predicted taken, and the predicted next fetch address. A small direct-mapped target cache answers the first and third questions. It is indexed by low address bits, checked with a tag taken from the high bits, and holds the target each branch jumped to the last time it was taken. A table of 2-bit saturating counters answers the second question. That table is indexed by the fetch address XORed with a global register of recent branch outcomes.

When a branch resolves in execute, the stage sends its address, its real direction, its real target and the next address that was predicted for it. The block then trains the counter, shifts the outcome into the history, and writes the target cache on taken branches. If the real next address differs from the predicted one, the block raises a one-cycle redirect carrying the correct address so that the pipeline can discard the wrong-path instructions. Under static sequential fetch with resolution in the ALU stage, such a redirect costs two bubbles. This block exists to make redirects rarer.

Top module: `npc_predictor`

## Requirements
- R1: After synchronous reset, pred_valid and flush_valid are 0, every target cache entry is empty, every counter holds 01 (weakly not taken) and the history is all zeros. A first fetch therefore reports pred_is_branch=0, pred_taken=0 and pred_npc=pc+INST_BYTES.
- R2: pred_npc equals the stored target when pred_is_branch and pred_taken are both 1. Otherwise it equals pred_pc+INST_BYTES.
- R3: pred_is_branch is 1 only when the entry selected by address bits [OFS_W +: BTB_IDX_W] is occupied and its stored tag equals address bits [ADDR_W-1 : OFS_W+BTB_IDX_W], where OFS_W = log2(INST_BYTES). A different address that maps to the same entry misses.
- R4: The counter index for a fetch is address bits [OFS_W +: HIST_W] XOR the history. pred_taken is the counter's upper bit (1 = taken).
- R5: A resolve uses the index formed from res_pc and the current history. It increments the counter on taken and decrements it on not taken, saturating at 00 and 11.
- R6: Each resolve shifts res_taken into the history LSB. The oldest bit drops out of the MSB.
- R7: A taken resolve writes the tag and res_target into the entry for res_pc, replacing whatever the entry held. A not-taken resolve leaves the target cache unchanged.
- R8: One cycle after a resolve, flush_valid is 1 exactly when the real next address differs from res_pred_npc. The real next address is res_target if res_taken, else res_pc+INST_BYTES. flush_pc then carries that real next address.
- R9: The prediction for a fetch appears in the cycle after fetch_valid, and pred_valid follows fetch_valid with one cycle of delay. When a fetch and a resolve occur in the same cycle, the fetch sees the state from before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch address is presented |
| fetch_pc | input | ADDR_W | Address being fetched |
| res_valid | input | 1 | A branch resolved in execute |
| res_pc | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Real direction of the resolved branch |
| res_target | input | ADDR_W | Real target of the resolved branch |
| res_pred_npc | input | ADDR_W | Next address that was predicted for this branch |
| pred_valid | output | 1 | Prediction outputs are valid |
| pred_pc | output | ADDR_W | Fetch address the prediction belongs to |
| pred_is_branch | output | 1 | Target cache hit |
| pred_taken | output | 1 | Direction prediction |
| pred_npc | output | ADDR_W | Predicted next fetch address |
| flush_valid | output | 1 | Redirect and flush request |
| flush_pc | output | ADDR_W | Corrected fetch address |

## Verification
The bench builds the block with ADDR_W=16, BTB_IDX_W=3 and HIST_W=4, and keeps INST_BYTES at 4. Random fetch addresses are confined to a 64-word window. This makes tag conflicts in the eight-entry target cache frequent and makes counter aliasing through the XOR index a common event. The four-bit history wraps within a handful of resolves, so saturation at both counter ends and history-dependent indexing are reached quickly. The directed phases add same-cycle fetch and resolve of one address.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;

  // 2-bit saturating counter step
  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    ctr_t r;
    if (up) r = (c == 2'b11) ? c : c + 2'b01;
    else    r = (c == 2'b00) ? c : c - 2'b01;
    return r;
  endfunction

endpackage

// File: rtl/npc_btb.sv
module npc_btb #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_pc,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_target,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_pc,
  input  logic [ADDR_W-1:0] wr_target
);
  localparam int TAG_W   = ADDR_W - OFS_W - IDX_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int WORD_W  = TAG_W + ADDR_W;

  // tag and target kept in one plain array so it maps onto block RAM
  logic [WORD_W-1:0]  mem [ENTRIES];
  logic [ENTRIES-1:0] occ;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag;
  assign rd_idx = rd_pc[OFS_W +: IDX_W];
  assign rd_tag = rd_pc[ADDR_W-1 -: TAG_W];
  assign wr_idx = wr_pc[OFS_W +: IDX_W];

  logic [WORD_W-1:0] word_q;
  logic              occ_q;
  logic [TAG_W-1:0]  want_tag_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_pc[ADDR_W-1 -: TAG_W], wr_target};
    word_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ        <= '0;
      occ_q      <= 1'b0;
      want_tag_q <= '0;
    end else begin
      if (wr_en) occ[wr_idx] <= 1'b1;
      occ_q      <= occ[rd_idx];
      want_tag_q <= rd_tag;
    end
  end

  assign rd_hit    = occ_q && (word_q[WORD_W-1 -: TAG_W] == want_tag_q);
  assign rd_target = word_q[ADDR_W-1:0];
endmodule

// File: rtl/npc_dir_table.sv
module npc_dir_table
  import npc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr[i] <= CTR_RESET;
      rd_taken <= 1'b0;
    end else begin
      if (upd_en) ctr[upd_idx] <= ctr_step(ctr[upd_idx], upd_taken);
      rd_taken <= ctr[rd_idx][1];
    end
  end
endmodule

// File: rtl/npc_ghist.sv
module npc_ghist #(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
  end
endmodule

// File: rtl/npc_predictor.sv
module npc_predictor #(
  parameter int ADDR_W     = 32,
  parameter int BTB_IDX_W  = 4,
  parameter int HIST_W     = 6,
  parameter int INST_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  input  logic [ADDR_W-1:0] res_pred_npc,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_pc,
  output logic              pred_is_branch,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_npc,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_pc
);
  localparam int OFS_W = $clog2(INST_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  logic [HIST_W-1:0] ghist;
  logic [HIST_W-1:0] fetch_cidx, res_cidx;
  logic              btb_hit;
  logic [ADDR_W-1:0] btb_tgt;
  logic              dir_taken;
  logic [ADDR_W-1:0] res_actual;

  assign fetch_cidx = fetch_pc[OFS_W +: HIST_W] ^ ghist;
  assign res_cidx   = res_pc[OFS_W +: HIST_W] ^ ghist;
  assign res_actual = res_taken ? res_target : res_pc + STEP;

  npc_btb #(.ADDR_W(ADDR_W), .IDX_W(BTB_IDX_W), .OFS_W(OFS_W)) btb_i (
    .clk(clk), .rst(rst),
    .rd_pc(fetch_pc), .rd_hit(btb_hit), .rd_target(btb_tgt),
    .wr_en(res_valid && res_taken), .wr_pc(res_pc), .wr_target(res_target)
  );

  npc_dir_table #(.IDX_W(HIST_W)) dir_i (
    .clk(clk), .rst(rst),
    .rd_idx(fetch_cidx), .rd_taken(dir_taken),
    .upd_en(res_valid), .upd_idx(res_cidx), .upd_taken(res_taken)
  );

  npc_ghist #(.HIST_W(HIST_W)) hist_i (
    .clk(clk), .rst(rst),
    .shift_en(res_valid), .bit_in(res_taken), .hist(ghist)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid  <= 1'b0;
      pred_pc     <= '0;
      flush_valid <= 1'b0;
      flush_pc    <= '0;
    end else begin
      pred_valid  <= fetch_valid;
      pred_pc     <= fetch_pc;
      flush_valid <= res_valid && (res_actual != res_pred_npc);
      flush_pc    <= res_actual;
    end
  end

  assign pred_is_branch = btb_hit;
  assign pred_taken     = dir_taken;
  assign pred_npc       = (btb_hit && dir_taken) ? btb_tgt : pred_pc + STEP;
endmodule

// File: rtl/npc_predictor_chk.sv
module npc_predictor_chk #(
  parameter int ADDR_W     = 32,
  parameter int HIST_W     = 6,
  parameter int INST_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic              res_valid,
  input logic [ADDR_W-1:0] res_pc,
  input logic              res_taken,
  input logic [ADDR_W-1:0] res_target,
  input logic              pred_valid,
  input logic [ADDR_W-1:0] pred_pc,
  input logic              pred_is_branch,
  input logic [ADDR_W-1:0] pred_npc,
  input logic              flush_valid,
  input logic [ADDR_W-1:0] flush_pc,
  input logic [HIST_W-1:0] ghist
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid);
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !pred_valid);
  a_r2_miss_sequential: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_is_branch) |-> (pred_npc == pred_pc + STEP));
  a_r8_flush_needs_resolve: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (flush_pc == ($past(res_taken) ? $past(res_target) : $past(res_pc) + STEP)));
  a_r8_no_spurious_flush: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> !flush_valid);
  a_r6_history_shift: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (ghist == {$past(ghist[HIST_W-2:0]), $past(res_taken)}));
  a_r6_history_hold: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> $stable(ghist));
endmodule

bind npc_predictor npc_predictor_chk #(
  .ADDR_W(ADDR_W), .HIST_W(HIST_W), .INST_BYTES(INST_BYTES)
) chk_i (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .res_valid(res_valid),
  .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target),
  .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_is_branch(pred_is_branch),
  .pred_npc(pred_npc), .flush_valid(flush_valid), .flush_pc(flush_pc),
  .ghist(ghist)
);

// File: tb/npc_predictor_tb_top.sv
module npc_predictor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int BI = 3;
  localparam int HW = 4;
  localparam int IB = 4;
  localparam int OFS = 2;
  localparam int TW = AW - OFS - BI;

  logic          clk = 1'b0;
  logic          rst;
  logic          fetch_valid;
  logic [AW-1:0] fetch_pc;
  logic          res_valid;
  logic [AW-1:0] res_pc;
  logic          res_taken;
  logic [AW-1:0] res_target;
  logic [AW-1:0] res_pred_npc;
  logic          pred_valid;
  logic [AW-1:0] pred_pc;
  logic          pred_is_branch;
  logic          pred_taken;
  logic [AW-1:0] pred_npc;
  logic          flush_valid;
  logic [AW-1:0] flush_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_predictor #(.ADDR_W(AW), .BTB_IDX_W(BI), .HIST_W(HW), .INST_BYTES(IB)) dut_i (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_pred_npc(res_pred_npc),
    .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_is_branch(pred_is_branch),
    .pred_taken(pred_taken), .pred_npc(pred_npc),
    .flush_valid(flush_valid), .flush_pc(flush_pc)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  bit            m_occ [1<<BI];
  logic [TW-1:0] m_tag [1<<BI];
  logic [AW-1:0] m_tgt [1<<BI];
  logic [1:0]    m_ctr [1<<HW];
  logic [HW-1:0] m_hist;

  function automatic logic [1:0] sat(input logic [1:0] c, input bit up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < (1<<BI); i++) begin m_occ[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; end
    for (int i = 0; i < (1<<HW); i++) m_ctr[i] = 2'b01;
    m_hist = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; fetch_valid = 0; fetch_pc = '0; res_valid = 0; res_pc = '0;
    res_taken = 0; res_target = '0; res_pred_npc = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // model prediction for a fetch address using current reference state
  task automatic model_pred(input logic [AW-1:0] pc, output bit hit, output bit tk,
                            output logic [AW-1:0] npc);
    int bi, ci;
    bi  = int'(pc[OFS +: BI]);
    ci  = int'(pc[OFS +: HW] ^ m_hist);
    hit = m_occ[bi] && (m_tag[bi] == pc[AW-1 -: TW]);
    tk  = m_ctr[ci][1];
    npc = (hit && tk) ? m_tgt[bi] : pc + AW'(IB);
  endtask

  // one cycle: drive at negedge, model update, check at next negedge
  task automatic cycle(input string ph, input bit fv, input logic [AW-1:0] fpc,
                       input bit rv, input logic [AW-1:0] rpc, input bit rt,
                       input logic [AW-1:0] rtgt, input logic [AW-1:0] rpred);
    bit e_hit, e_tk, e_fl;
    logic [AW-1:0] e_npc, actual;
    int ui, bi;
    fetch_valid = fv; fetch_pc = fpc; res_valid = rv; res_pc = rpc;
    res_taken = rt; res_target = rtgt; res_pred_npc = rpred;
    model_pred(fpc, e_hit, e_tk, e_npc);
    actual = rt ? rtgt : rpc + AW'(IB);
    e_fl   = rv && (actual != rpred);
    if (rv) begin
      ui = int'(rpc[OFS +: HW] ^ m_hist);
      m_ctr[ui] = sat(m_ctr[ui], rt);
      if (rt) begin
        bi = int'(rpc[OFS +: BI]);
        m_occ[bi] = 1; m_tag[bi] = rpc[AW-1 -: TW]; m_tgt[bi] = rtgt;
      end
      m_hist = {m_hist[HW-2:0], rt};
    end
    @(negedge clk);
    chk(pred_valid == fv, {"R9 pred_valid ", ph}, AW'(pred_valid), AW'(fv));
    if (fv) begin
      chk(pred_is_branch == e_hit, {"R3 hit ", ph}, AW'(pred_is_branch), AW'(e_hit));
      chk(pred_taken == e_tk, {"R4 R5 R6 taken ", ph}, AW'(pred_taken), AW'(e_tk));
      chk(pred_npc == e_npc, {"R2 R7 npc ", ph}, pred_npc, e_npc);
    end
    chk(flush_valid == e_fl, {"R8 flush_valid ", ph}, AW'(flush_valid), AW'(e_fl));
    if (e_fl) chk(flush_pc == actual, {"R8 flush_pc ", ph}, flush_pc, actual);
  endtask

  localparam logic [AW-1:0] P = 16'h0140;
  localparam logic [AW-1:0] Q = 16'h0248;

  initial begin
    void'($urandom(32'd20240607));
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk(pred_valid == 0, "R1 pred_valid after reset", AW'(pred_valid), '0);
    chk(flush_valid == 0, "R1 flush_valid after reset", AW'(flush_valid), '0);
    cycle("R1 first fetch", 1, P, 0, '0, 0, '0, '0);
    chk(pred_npc == P + 4, "R1 sequential after reset", pred_npc, P + 4);

    // R5: train P taken until saturated, history fills with ones
    for (int i = 0; i < 7; i++) cycle("R5 train up", 0, '0, 1, P, 1, 16'h0800, P + 4);
    cycle("R5 predict saturated", 1, P, 0, '0, 0, '0, '0);
    chk(pred_npc == 16'h0800, "R5 R7 taken target", pred_npc, 16'h0800);
    cycle("R5 one down", 0, '0, 1, P, 0, '0, 16'h0800);
    for (int i = 0; i < 6; i++) cycle("R5 train down", 1, P, 1, P, 0, '0, P + 4);

    // R6: alternating outcomes steer the counter index
    for (int i = 0; i < 8; i++) cycle("R6 history", 1, Q + AW'(4*i), 1, Q, i[0], 16'h0900, Q + 4);

    // R7: not-taken resolve must not allocate
    cycle("R7 not taken", 0, '0, 1, 16'h03a0, 0, '0, 16'h03a4);
    cycle("R7 probe", 1, 16'h03a0, 0, '0, 0, '0, '0);
    chk(pred_is_branch == 0, "R7 no allocation", AW'(pred_is_branch), '0);

    // R3: alias with same index, different tag
    cycle("R3 alloc", 0, '0, 1, 16'h0104, 1, 16'h0a00, 16'h0108);
    cycle("R3 alias", 1, 16'h0104 + 16'h0020, 0, '0, 0, '0, '0);

    // R9: same-cycle fetch and resolve of one address sees old state
    cycle("R9 collide", 1, 16'h0104, 1, 16'h0104, 1, 16'h0b00, 16'h0b00);
    cycle("R9 after", 1, 16'h0104, 0, '0, 0, '0, '0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] fpc, rpc, tgt, rpred;
      bit hh, tt;
      logic [AW-1:0] pn;
      fpc = 16'h0100 + AW'(($urandom % 64) * 4);
      rpc = 16'h0100 + AW'(($urandom % 64) * 4);
      tgt = AW'(($urandom % 1024) * 4);
      model_pred(rpc, hh, tt, pn);
      case ($urandom % 3)
        0: rpred = pn;
        1: rpred = rpc + 4;
        default: rpred = tgt;
      endcase
      cycle("R2 random", ($urandom % 4) != 0, fpc, ($urandom % 3) != 0, rpc,
            ($urandom % 2) == 1, tgt, rpred);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired R9 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule